// File: doc/BRIEF.md
# Ethernet Frame Check Sequence Stream Unit

The block computes the 32-bit Ethernet frame check sequence over a frame that arrives as a stream of multi-byte words, one word per clock. A word is taken when `in_valid` is high. `in_sof` marks the first word of a frame and `in_eof` marks the last. On the last word, `in_keep` says how many of the leading byte lanes carry frame bytes. One clock after the last word is absorbed, the block presents the sealed FCS on `fcs_out` and pulses `fcs_valid` for one cycle.

In check mode, the frame is fed together with its received FCS appended. The block then raises `fcs_match` alongside `fcs_valid` when the CRC register holds the fixed residue that an undamaged frame leaves. The CRC uses the generator 0x04C11DB7, bit-reflected, with an all-ones preset and an inverted result. Each frame byte is absorbed through its own unrolled eight-bit stage, so a whole word is consumed in a single cycle.

A small controller tracks frame position with three states. `ST_IDLE` means no frame is open. `ST_BODY` means a frame is open and words are being absorbed. `ST_DONE` is the one-cycle result state. The transitions are:

- `ST_IDLE`/`ST_DONE` → `ST_BODY` on valid with start and without end.
- `ST_IDLE`/`ST_DONE` → `ST_DONE` on valid with both start and end (a single-word frame).
- `ST_IDLE`/`ST_DONE` → `ST_IDLE` otherwise.
- `ST_BODY` → `ST_DONE` on valid with end.
- `ST_BODY` → `ST_BODY` otherwise. This includes a start received mid-frame, which restarts the CRC.

Top module: `fcs_stream_unit`

## Requirements
- R1: During and right after reset, `fcs_valid` and `fcs_match` are 0, `fcs_out` is 0, and the controller is in `ST_IDLE`.
- R2: Byte lane 0 (`in_data[7:0]`) is the earliest byte of a word, and each byte is absorbed least significant bit first. The CRC uses generator 0x04C11DB7 with preset 0xFFFFFFFF, and the result is inverted. For the nine ASCII bytes "123456789", `fcs_out` is 0xCBF43926.
- R3: Every word that is not the last word absorbs all BYTES lanes in one cycle. For any frame length, `fcs_out` equals the CRC of the frame's bytes.
- R4: On the last word, the number of absorbed bytes equals the count of consecutive ones in `in_keep` starting at bit 0. Lanes beyond that count have no effect on `fcs_out`. On other words, `in_keep` is ignored.
- R5: `in_sof` with `in_valid` loads the preset in the same cycle the first word is absorbed. This holds mid-frame too, so bytes taken before the restart do not affect the result.
- R6: Cycles with `in_valid` low do not change the CRC state, so idle gaps inside a frame leave the result unchanged.
- R7: A valid word that arrives while no frame is open and without `in_sof` is ignored. It raises no `fcs_valid`, leaves `fcs_out` unchanged, and leaves the controller in `ST_IDLE`.
- R8: `fcs_valid` is high exactly in the cycle after a last word is absorbed. `fcs_out` changes only at that point and holds its value otherwise.
- R9: When `check_mode` is sampled high with the last word, `fcs_match` is 1 in the `fcs_valid` cycle if the bit-reversed CRC register equals the residue 0xC704DD7B. This happens when the frame is followed by its FCS, least significant byte first. In all other cases `fcs_match` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| check_mode | input | 1 | Compare against the residue, sampled with the last word |
| in_valid | input | 1 | Word on `in_data` is present this cycle |
| in_sof | input | 1 | First word of a frame |
| in_eof | input | 1 | Last word of a frame |
| in_keep | input | BYTES | Lane enables on the last word, contiguous from lane 0 |
| in_data | input | 8*BYTES | Frame bytes, lane 0 earliest |
| fcs_valid | output | 1 | One-cycle pulse, result present |
| fcs_out | output | 32 | Inverted CRC of the last frame |
| fcs_match | output | 1 | Residue matched, check mode only |

## Verification
The bench sweeps frame lengths across every remainder of the final word and fills the unused lanes with noise. A design that picked the wrong unrolled stage, or that let a disabled lane leak into the CRC, would produce a wrong FCS for exactly those lengths. Restart and idle-gap cases catch a register that fails to preset on a mid-frame start or that advances on invalid cycles. Stray words outside a frame would otherwise raise a spurious result pulse. Check-mode runs with intact, corrupted and non-check frames show whether the residue compare uses the right bit order and is gated by the mode.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    localparam logic [31:0] FCS_PRESET = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BODY = 2'd1,
        ST_DONE = 2'd2
    } ctl_state_t;

    // Mirror a 32-bit word end to end.
    function automatic logic [31:0] mirror32(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) begin
            r[i] = v[31 - i];
        end
        return r;
    endfunction

    // Absorb one byte, least significant bit first, into a reflected register.
    function automatic logic [31:0] absorb_byte(input logic [31:0] crc,
                                                input logic [7:0]  octet,
                                                input logic [31:0] rpoly);
        logic [31:0] r;
        r = crc ^ {24'd0, octet};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ rpoly) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/fcs_lane_chain.sv
// Unrolled chain: tap k holds the register after the first k lanes.
module fcs_lane_chain #(
    parameter int          BYTES = 4,
    parameter logic [31:0] POLY  = 32'h04C1_1DB7
) (
    input  logic [31:0]            seed,
    input  logic [8*BYTES-1:0]     lanes,
    output logic [BYTES:0][31:0]   taps
);
    import fcs_pkg::*;

    localparam logic [31:0] RPOLY = mirror32(POLY);

    assign taps[0] = seed;

    for (genvar k = 0; k < BYTES; k++) begin : g_stage
        assign taps[k+1] = absorb_byte(taps[k], lanes[8*k +: 8], RPOLY);
    end
endmodule

// File: rtl/fcs_keep_decode.sv
// Counts consecutive set enables from lane 0.
module fcs_keep_decode #(
    parameter int BYTES = 4,
    localparam int CW   = $clog2(BYTES + 1)
) (
    input  logic [BYTES-1:0] keep,
    output logic [CW-1:0]    count
);
    always_comb begin
        logic run;
        run   = 1'b1;
        count = '0;
        for (int k = 0; k < BYTES; k++) begin
            if (run && keep[k]) begin
                count = CW'(k + 1);
            end else begin
                run = 1'b0;
            end
        end
    end
endmodule

// File: rtl/fcs_frame_ctrl.sv
// Frame position controller.
module fcs_frame_ctrl (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic                  in_sof,
    input  logic                  in_eof,
    output logic                  take,
    output logic                  preset,
    output logic                  seal,
    output logic                  result_valid,
    output fcs_pkg::ctl_state_t   state
);
    import fcs_pkg::*;

    ctl_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (in_valid && in_sof) begin
                    state_d = in_eof ? ST_DONE : ST_BODY;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_BODY: begin
                if (in_valid && in_eof) begin
                    state_d = ST_DONE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        preset       = in_valid && in_sof;
        take         = in_valid && (in_sof || state_q == ST_BODY);
        seal         = take && in_eof;
        result_valid = (state_q == ST_DONE);
        state        = state_q;
    end
endmodule

// File: rtl/fcs_stream_unit.sv
module fcs_stream_unit #(
    parameter int          BYTES   = 4,
    parameter logic [31:0] POLY    = 32'h04C1_1DB7,
    parameter logic [31:0] RESIDUE = 32'hC704_DD7B,
    localparam int         CW      = $clog2(BYTES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 check_mode,
    input  logic                 in_valid,
    input  logic                 in_sof,
    input  logic                 in_eof,
    input  logic [BYTES-1:0]     in_keep,
    input  logic [8*BYTES-1:0]   in_data,
    output logic                 fcs_valid,
    output logic [31:0]          fcs_out,
    output logic                 fcs_match
);
    import fcs_pkg::*;

    logic                 take, preset, seal;
    ctl_state_t           ctl_state;
    logic [31:0]          crc_q;
    logic [31:0]          seed;
    logic [BYTES:0][31:0] taps;
    logic [CW-1:0]        keep_cnt;
    logic [CW-1:0]        used;
    logic [31:0]          crc_next;

    fcs_frame_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_sof       (in_sof),
        .in_eof       (in_eof),
        .take         (take),
        .preset       (preset),
        .seal         (seal),
        .result_valid (fcs_valid),
        .state        (ctl_state)
    );

    fcs_keep_decode #(.BYTES(BYTES)) u_keep (
        .keep  (in_keep),
        .count (keep_cnt)
    );

    // A start reloads the preset in the cycle the first word is absorbed.
    assign seed = preset ? FCS_PRESET : crc_q;

    fcs_lane_chain #(.BYTES(BYTES), .POLY(POLY)) u_chain (
        .seed  (seed),
        .lanes (in_data),
        .taps  (taps)
    );

    assign used     = in_eof ? keep_cnt : CW'(BYTES);
    assign crc_next = taps[used];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q     <= FCS_PRESET;
            fcs_out   <= '0;
            fcs_match <= 1'b0;
        end else begin
            if (take) begin
                crc_q <= crc_next;
            end
            if (seal) begin
                fcs_out   <= ~crc_next;
                fcs_match <= check_mode && (mirror32(crc_next) == RESIDUE);
            end else begin
                fcs_match <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/fcs_stream_checker.sv
module fcs_stream_checker (
    input logic                clk,
    input logic                rst_n,
    input logic                check_mode,
    input logic                in_valid,
    input logic                in_sof,
    input logic                in_eof,
    input logic                fcs_valid,
    input logic                fcs_match,
    input logic [31:0]         fcs_out,
    input logic [31:0]         crc_q,
    input fcs_pkg::ctl_state_t st
);
    import fcs_pkg::*;

    AST_RESULT_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_eof && (in_sof || st == ST_BODY)) |=> fcs_valid); // R8

    AST_RESULT_NEEDS_END: assert property (@(posedge clk) disable iff (!rst_n)
        fcs_valid |-> $past(in_valid && in_eof)); // R8

    AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !fcs_valid |-> $stable(fcs_out)); // R8

    AST_MATCH_IN_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        fcs_match |-> (fcs_valid && $past(check_mode))); // R9

    AST_STRAY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_BODY && in_valid && !in_sof) |=> (st == ST_IDLE && !fcs_valid)); // R7

    AST_GAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BODY && !in_valid) |=> $stable(crc_q)); // R6

    AST_START_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof && !in_eof) |=> (st == ST_BODY)); // R5
endmodule

bind fcs_stream_unit fcs_stream_checker i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .check_mode (check_mode),
    .in_valid   (in_valid),
    .in_sof     (in_sof),
    .in_eof     (in_eof),
    .fcs_valid  (fcs_valid),
    .fcs_match  (fcs_match),
    .fcs_out    (fcs_out),
    .crc_q      (crc_q),
    .st         (ctl_state)
);

// File: tb/test_fcs_stream_unit.sv
`timescale 1ns/1ps
module test_fcs_stream_unit;
    localparam int B = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           check_mode = 1'b0;
    logic           in_valid = 1'b0;
    logic           in_sof = 1'b0;
    logic           in_eof = 1'b0;
    logic [B-1:0]   in_keep = '0;
    logic [8*B-1:0] in_data = '0;
    logic           fcs_valid;
    logic [31:0]    fcs_out;
    logic           fcs_match;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;
    logic [7:0] fbuf [0:79];

    always #2.5 clk = ~clk;

    fcs_stream_unit #(.BYTES(B)) i_fcs_stream_unit (
        .clk(clk), .rst_n(rst_n), .check_mode(check_mode),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
        .in_keep(in_keep), .in_data(in_data),
        .fcs_valid(fcs_valid), .fcs_out(fcs_out), .fcs_match(fcs_match)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Bit-serial reference register (reflected, no final inversion).
    function automatic logic [31:0] ref_reg(input int len);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int n = 0; n < len; n++) begin
            for (int i = 0; i < 8; i++) begin
                logic fb;
                fb = c[0] ^ fbuf[n][i];
                c  = c >> 1;
                if (fb) c = c ^ 32'hEDB8_8320;
            end
        end
        return c;
    endfunction

    task automatic send_frame(input int len, input bit chk, input int gap);
        int nw = (len + B - 1) / B;
        for (int w = 0; w < nw; w++) begin
            @(negedge clk);
            in_valid   = 1'b1;
            in_sof     = (w == 0);
            in_eof     = (w == nw - 1);
            check_mode = chk;
            for (int l = 0; l < B; l++) begin
                int idx = w * B + l;
                in_data[8*l +: 8] = (idx < len) ? fbuf[idx] : (8'hC3 ^ 8'(idx * 7));
                in_keep[l]        = (w == nw - 1) ? (idx < len) : 1'b0;
            end
            if (w != nw - 1) begin
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    in_valid = 1'b0;
                    in_sof   = 1'b0;
                    in_data  = 32'hDEAD_BEEF;
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sof   = 1'b0;
        in_eof   = 1'b0;
    endtask

    task automatic fill(input int len, input int s);
        for (int n = 0; n < len; n++) fbuf[n] = 8'(n * 37 + s * 11 + (n >> 2) * 5);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r, held;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(fcs_valid == 0 && fcs_match == 0 && fcs_out == 0, "R1", {fcs_valid, fcs_match, fcs_out[29:0]}, 0);
        rst_n = 1'b1;

        // R2: check string
        for (int n = 0; n < 9; n++) fbuf[n] = 8'h31 + 8'(n);
        send_frame(9, 0, 0);
        check(fcs_valid == 1, "R8 pulse", fcs_valid, 1);
        check(fcs_out == 32'hCBF4_3926, "R2 check string", fcs_out, 32'hCBF43926);
        @(negedge clk);
        check(fcs_valid == 0 && fcs_out == 32'hCBF4_3926, "R8 hold", fcs_out, 32'hCBF43926);

        // R3/R4: length sweep with noise in unused lanes, with and without gaps (R6)
        for (int len = 1; len <= 24; len++) begin
            fill(len, len);
            send_frame(len, 0, len % 3);
            r = ~ref_reg(len);
            check(fcs_out == r, (len % B) ? "R4 partial word" : "R3 full words", fcs_out, r);
            if (len % 3) check(fcs_out == r, "R6 gaps", fcs_out, r);
            check(fcs_match == 0, "R9 no check mode", fcs_match, 0);
        end

        // R7: stray words with no open frame
        held = fcs_out;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            in_valid = 1; in_sof = 0; in_eof = k[0]; in_keep = 4'hF; in_data = 32'h1234_5678 + k;
        end
        @(negedge clk);
        in_valid = 0; in_eof = 0;
        check(fcs_valid == 0 && fcs_out == held, "R7 stray ignored", fcs_out, held);
        @(negedge clk);
        check(fcs_valid == 0 && fcs_out == held, "R7 stray ignored later", fcs_out, held);

        // R5: restart mid-frame
        @(negedge clk);
        in_valid = 1; in_sof = 1; in_eof = 0; in_data = 32'hFFEE_DDCC;
        @(negedge clk);
        in_sof = 0; in_data = 32'h0102_0304;
        fill(11, 99);
        send_frame(11, 0, 0);
        r = ~ref_reg(11);
        check(fcs_out == r, "R5 restart", fcs_out, r);

        // R9: check mode with appended FCS, corrupted, and mode off
        for (int len = 1; len <= 12; len++) begin
            fill(len, len + 50);
            r = ~ref_reg(len);
            for (int k = 0; k < 4; k++) fbuf[len + k] = r[8*k +: 8];
            send_frame(len + 4, 1, 0);
            check(fcs_match == 1 && fcs_valid == 1, "R9 intact", fcs_match, 1);
            fbuf[len - 1] = fbuf[len - 1] ^ 8'h10;
            send_frame(len + 4, 1, 0);
            check(fcs_match == 0, "R9 corrupted", fcs_match, 0);
            fbuf[len - 1] = fbuf[len - 1] ^ 8'h10;
            send_frame(len + 4, 0, 0);
            check(fcs_match == 0, "R9 mode off", fcs_match, 0);
        end

        // R2: single-word frame with start and end together
        fbuf[0] = 8'h31; fbuf[1] = 8'h32;
        send_frame(2, 0, 0);
        r = ~ref_reg(2);
        check(fcs_out == r && fcs_valid == 1, "R2 single word", fcs_out, r);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule